// File: doc/BRIEF.md
# Shift-Rotate Unit with Carry

A purely combinational 32-bit shifter for the execute stage of a small processor. In one pass it performs an arithmetic or logical right shift, a logical left shift, a right rotate, a left rotate, or a one-bit right rotate that runs through the carry flag. It returns the shifted word and the carry-out, which is the last bit that left the word. It also returns a strobe that tells the flag register whether to take that carry.

Each operation accepts its own range of shift amounts. An amount outside that range does not change the operand. A left rotate uses the same right-rotate path with the complementary distance. The caller asks for a carry update through an enable pin, and the unit passes that request on only when the operation is legal.

Top module: `srt_unit`

## Requirements
- R1: Arithmetic shift right (op code 0) by n, 1 <= n <= 32, fills the vacated high bits with operand bit 31. carry_out is operand bit n-1.
- R2: Logical shift right (op code 1) by n, 1 <= n <= 32, fills the vacated high bits with zeros. carry_out is operand bit n-1.
- R3: Logical shift left (op code 2) by n, 0 <= n <= 31, fills the low bits with zeros. For n >= 1, carry_out is operand bit 32-n. For n = 0, result equals the operand and carry_out equals carry_in.
- R4: Rotate right (op code 3) by n, 1 <= n <= 31, brings the bits that leave bit 0 back in at bit 31. carry_out is result bit 31, which is the last bit rotated out.
- R5: Extended rotate (op code 4) ignores amount. The result is {carry_in, operand[31:1]} and carry_out is operand bit 0.
- R6: Rotate left (op code 5) by n, 1 <= n <= 31, gives the same result and carry_out as op code 3 with amount 32-n.
- R7: An amount outside the range of the selected operation, and op codes 6 and 7, return result equal to the operand and carry_out equal to carry_in.
- R8: carry_upd is high exactly when flag_en is high and the operation and amount are legal. With all inputs zero, result, carry_out and carry_upd are zero.
- R9: A right shift by exactly 32 gives 32 copies of operand bit 31 for op code 0 and zero for op code 1. In both cases carry_out is operand bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 32 | Word to shift or rotate |
| amount | input | 6 | Shift or rotate distance |
| op | input | 3 | Operation code (see requirements) |
| carry_in | input | 1 | Current carry flag |
| flag_en | input | 1 | Request to update the carry flag |
| result | output | 32 | Shifted or rotated word |
| carry_out | output | 1 | Last bit moved out, or carry_in when nothing moves |
| carry_upd | output | 1 | Carry flag write strobe |

## Verification
Some properties are checked on every input change by assertions:
- the write strobe is gated by the enable;
- illegal requests and a left shift by zero pass the operand through;
- an extended rotate and a full-width right shift report the correct carry;
- any rotate keeps the population count of the word.

The bit-exact values for every operation and every amount from 0 to 63 can only come from the bench. It compares them against a one-bit-per-step reference model, on corner operands and on seeded random words. That bench sweep also shows where each legal range ends, and that a left rotate matches a right rotate by the complementary distance.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [2:0] {
    OP_ASR  = 3'd0,
    OP_LSR  = 3'd1,
    OP_LSL  = 3'd2,
    OP_ROR  = 3'd3,
    OP_RRX  = 3'd4,
    OP_ROL  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } srt_op_e;
endpackage

// File: rtl/srt_range.sv
module srt_range
  import srt_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W) + 1
) (
  input  srt_op_e         op,
  input  logic [AW-1:0]   amt,
  output logic            legal,
  output logic [AW-1:0]   eff_amt
);
  localparam logic [AW-1:0] FULL = AW'(W);
  localparam logic [AW-1:0] TOP  = AW'(W - 1);

  function automatic logic in_range(logic [AW-1:0] n, logic [AW-1:0] lo,
                                    logic [AW-1:0] hi);
    return (n >= lo) && (n <= hi);
  endfunction

  always_comb begin
    unique case (op)
      OP_ASR, OP_LSR: legal = in_range(amt, AW'(1), FULL);
      OP_LSL:         legal = in_range(amt, AW'(0), TOP);
      OP_ROR, OP_ROL: legal = in_range(amt, AW'(1), TOP);
      OP_RRX:         legal = 1'b1;
      default:        legal = 1'b0;
    endcase
  end

  // a left rotate becomes a right rotate by the complementary distance
  assign eff_amt = (op == OP_ROL) ? (FULL - amt) : amt;
endmodule

// File: rtl/srt_right.sv
module srt_right #(
  parameter int W  = 32,
  parameter int AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  opnd,
  input  logic [AW-1:0] amt,
  input  logic          rotate,
  input  logic          arith,
  output logic [W-1:0]  res,
  output logic          cout
);
  // returns {result, carry}; a guard bit below the word catches the last bit out
  function automatic logic [W:0] right_core(logic [W-1:0] v, logic [W-1:0] hi,
                                            logic [AW-1:0] n);
    logic [2*W:0] t;
    t = {hi, v, 1'b0} >> n;
    return t[W:0];
  endfunction

  logic [W-1:0] upper;
  logic [W:0]   packed_out;

  assign upper      = rotate ? opnd : (arith ? {W{opnd[W-1]}} : '0);
  assign packed_out = right_core(opnd, upper, amt);
  assign res        = packed_out[W:1];
  assign cout       = packed_out[0];
endmodule

// File: rtl/srt_left.sv
module srt_left #(
  parameter int W  = 32,
  parameter int AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  opnd,
  input  logic [AW-1:0] amt,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout
);
  function automatic logic [W:0] left_core(logic [W-1:0] v, logic [AW-1:0] n);
    return {1'b0, v} << n;
  endfunction

  logic [W:0] t;
  assign t    = left_core(opnd, amt);
  assign res  = t[W-1:0];
  assign cout = (amt == '0) ? cin : t[W];
endmodule

// File: rtl/srt_unit.sv
module srt_unit
  import srt_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  operand,
  input  logic [AW-1:0] amount,
  input  logic [2:0]    op,
  input  logic          carry_in,
  input  logic          flag_en,
  output logic [W-1:0]  result,
  output logic          carry_out,
  output logic          carry_upd
);
  srt_op_e       op_e;
  logic          amt_legal;
  logic [AW-1:0] eff_amt;
  logic [W-1:0]  rt_res, lt_res;
  logic          rt_cout, lt_cout;
  logic          is_rot;

  assign op_e   = srt_op_e'(op);
  assign is_rot = (op_e == OP_ROR) || (op_e == OP_ROL);

  srt_range #(.W(W), .AW(AW)) u_range (
    .op(op_e), .amt(amount), .legal(amt_legal), .eff_amt(eff_amt)
  );

  srt_right #(.W(W), .AW(AW)) u_right (
    .opnd(operand), .amt(eff_amt), .rotate(is_rot), .arith(op_e == OP_ASR),
    .res(rt_res), .cout(rt_cout)
  );

  srt_left #(.W(W), .AW(AW)) u_left (
    .opnd(operand), .amt(amount), .cin(carry_in), .res(lt_res), .cout(lt_cout)
  );

  always_comb begin
    result    = operand;
    carry_out = carry_in;
    if (amt_legal) begin
      unique case (op_e)
        OP_LSL: begin result = lt_res; carry_out = lt_cout; end
        OP_RRX: begin result = {carry_in, operand[W-1:1]}; carry_out = operand[0]; end
        default: begin result = rt_res; carry_out = rt_cout; end
      endcase
    end
  end

  assign carry_upd = flag_en & amt_legal;

  always_comb begin
    AST_UPD_NEEDS_EN: assert (flag_en || !carry_upd); // R8
    AST_ILLEGAL_PASS: assert (amt_legal || (result == operand && carry_out == carry_in)); // R7
    AST_LSL_ZERO: assert (!(op_e == OP_LSL && amount == '0) || (result == operand && carry_out == carry_in)); // R3
    AST_RRX_CARRY: assert (op_e != OP_RRX || carry_out == operand[0]); // R5
    AST_FULL_RIGHT: assert (!((op_e == OP_ASR || op_e == OP_LSR) && amount == AW'(W)) || carry_out == operand[W-1]); // R9
    AST_ROT_POPCOUNT: assert (!(is_rot && amt_legal) || $countones(result) == $countones(operand)); // R4
  end
endmodule

// File: tb/sim_srt_unit.sv
module sim_srt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] operand = '0;
  logic [5:0]  amount = '0;
  logic [2:0]  op = '0;
  logic        carry_in = 1'b0;
  logic        flag_en = 1'b0;
  logic [31:0] result;
  logic        carry_out, carry_upd;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  srt_unit u0 (
    .operand(operand), .amount(amount), .op(op), .carry_in(carry_in),
    .flag_en(flag_en), .result(result), .carry_out(carry_out), .carry_upd(carry_upd)
  );

  function automatic bit ref_legal(int o, int n);
    case (o)
      0, 1:    return n >= 1 && n <= 32;
      2:       return n <= 31;
      3, 5:    return n >= 1 && n <= 31;
      4:       return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // step-by-step model: {carry, result}
  function automatic logic [32:0] ref_model(int o, logic [31:0] v, int n, logic c);
    logic [31:0] r = v;
    logic        k = c;
    if (!ref_legal(o, n)) return {c, v};
    case (o)
      0: for (int i = 0; i < n; i++) begin k = r[0]; r = {r[31], r[31:1]}; end
      1: for (int i = 0; i < n; i++) begin k = r[0]; r = {1'b0, r[31:1]}; end
      2: for (int i = 0; i < n; i++) begin k = r[31]; r = {r[30:0], 1'b0}; end
      3: for (int i = 0; i < n; i++) begin k = r[0]; r = {r[0], r[31:1]}; end
      4: begin k = v[0]; r = {c, v[31:1]}; end
      5: begin for (int i = 0; i < n; i++) r = {r[30:0], r[31]}; k = r[31]; end
      default: ;
    endcase
    return {k, r};
  endfunction

  function automatic string req_tag(int o, int n);
    if (!ref_legal(o, n)) return "R7";
    if (o <= 1 && n == 32) return "R9";
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s op=%0d amt=%0d opnd=%h actual=%h expected=%h",
               tag, what, op, amount, operand, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] v, int o, int n, logic c, logic en);
    logic [32:0] e;
    @(negedge clk);
    operand = v; op = 3'(o); amount = 6'(n); carry_in = c; flag_en = en;
    #1;
    e = ref_model(o, v, n, c);
    check(req_tag(o, n), result, e[31:0], "result");
    check(req_tag(o, n), {31'b0, carry_out}, {31'b0, e[32]}, "carry");
    check("R8", {31'b0, carry_upd}, {31'b0, en & ref_legal(o, n)}, "upd");
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // all-zero inputs R8
    check("R8", result, 32'h0, "zero-result");
    check("R8", {31'b0, carry_out, carry_upd}, 32'h0, "zero-flags");
    for (int t = 0; t < 16; t++) begin
      case (t)
        0: v = 32'h8000_0001;
        1: v = 32'h7FFF_FFFE;
        2: v = 32'h0000_0000;
        3: v = 32'hFFFF_FFFF;
        default: v = $urandom;
      endcase
      for (int o = 0; o < 8; o++)
        for (int n = 0; n < 64; n++)
          apply(v, o, n, 1'($urandom), 1'($urandom));
    end
    // directed: rotate-left equals rotate-right by complement R6
    for (int n = 1; n < 32; n++) apply(32'hDEAD_BEEF, 5, n, 1'b0, 1'b1);
    // LSL by 0 keeps carry of either polarity R3
    apply(32'h1234_5678, 2, 0, 1'b1, 1'b1);
    apply(32'h1234_5678, 2, 0, 1'b0, 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule